// File: doc/BRIEF.md
# Zero-Page Single-Bit Sequencer

This block is an execution sequencer for an 8-bit processor core. It takes one opcode that sets, clears or tests a single bit of a byte in page zero, and runs the memory cycles that the operation needs. The two modify forms read the byte, spend one idle cycle, and write the byte back with one bit forced. The two test forms read the byte and pick the next program counter from the value of the selected bit.

The core hands over the opcode byte, the zero-page address, the branch displacement and the address of the opcode, and pulses `start`. While the block is busy it ignores further starts. When the operation finishes it presents the next program counter and raises `done` for one clock. The memory port is synchronous. Read data appears on `mem_rdata` in the cycle after `mem_rd` is high.

Top module: `zpbit_unit`

## Requirements
- R1: An opcode of the form 1nnn0111 (binary) writes back the addressed byte with bit n set to 1 and every other bit unchanged.
- R2: An opcode of the form 0nnn0111 writes back the addressed byte with bit n cleared to 0 and every other bit unchanged.
- R3: An opcode of the form 1nnn1111 returns next_pc = pc + 3 + sign-extended offset when bit n of the byte is 1, and returns pc + 3 otherwise. The sum wraps modulo 2^16.
- R4: An opcode of the form 0nnn1111 returns next_pc = pc + 3 + sign-extended offset when bit n of the byte is 0, and returns pc + 3 otherwise. The sum wraps modulo 2^16.
- R5: The set and clear forms return next_pc = pc + 2, modulo 2^16.
- R6: Whenever mem_rd or mem_wr is high, mem_addr equals {8'h00, zp_addr}, using the zero-page address that was accepted with the operation.
- R7: For the set and clear forms, mem_rd is high in the first cycle after acceptance and both strobes are low in the second. mem_wr is high in the third cycle, and done is high in the fourth. Exactly one write occurs.
- R8: The test forms never raise mem_wr, do not change memory, and raise done in the third cycle after acceptance.
- R9: done is high for exactly one cycle per operation. busy is high from the cycle after acceptance up to the cycle in which done rises.
- R10: A start while busy is high is ignored. The running operation completes unchanged and no second operation runs.
- R11: A start whose opcode has a low nibble other than 7 or F is ignored. busy stays low, no memory cycle occurs and done is not raised.
- R12: During and right after reset, busy, done, mem_rd and mem_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the operation on the inputs below |
| opcode | input | 8 | Opcode byte selecting the operation and the bit index |
| zp_addr | input | 8 | Zero-page byte address |
| offset | input | 8 | Signed branch displacement |
| pc_in | input | 16 | Address of the opcode byte |
| mem_rdata | input | 8 | Read data, valid in the cycle after mem_rd |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | 16 | Program counter after the operation, valid with done |

## Verification
All 32 legal opcodes are run against the data bytes 0x00, 0xFF, 0x55 and 0xAA, with varying addresses. For each opcode this puts the selected bit in both states, and the alternating patterns show whether neighbouring bits stay untouched. This separates a wrong bit index or wrong polarity from a correct modify. Offsets of 0x7F, 0x80, 0x00 and 0xFD are paired with program counters near 0xFFFF and near 0x0000, which exposes missing sign extension and missing wrap. Starts while busy and starts with illegal opcodes confirm that neither reaches the memory port.

// File: rtl/zpbit_pkg.sv
package zpbit_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        OP_CLRB = 2'd0,
        OP_SETB = 2'd1,
        OP_BRB0 = 2'd2,
        OP_BRB1 = 2'd3
    } zop_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_WRITE = 2'd3
    } zstate_e;

    typedef struct packed {
        logic             legal;
        zop_e             op;
        logic [IDX_W-1:0] idx;
    } zdec_t;

    function automatic zdec_t decode_opcode(input logic [BYTE_W-1:0] opc);
        zdec_t d;
        d.legal = (opc[3:0] == 4'h7) || (opc[3:0] == 4'hF);
        d.idx   = opc[6:4];
        case ({opc[3], opc[7]})
            2'b00:   d.op = OP_CLRB;
            2'b01:   d.op = OP_SETB;
            2'b10:   d.op = OP_BRB0;
            default: d.op = OP_BRB1;
        endcase
        return d;
    endfunction

    function automatic logic op_is_branch(input zop_e op);
        return (op == OP_BRB0) || (op == OP_BRB1);
    endfunction

    function automatic logic [BYTE_W-1:0] one_hot(input logic [IDX_W-1:0] idx);
        logic [BYTE_W-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/zpbit_decode.sv
module zpbit_decode
    import zpbit_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output zdec_t             dec
);
    always_comb begin
        dec = decode_opcode(opcode);
    end
endmodule

// File: rtl/zpbit_bitop.sv
module zpbit_bitop
    import zpbit_pkg::*;
(
    input  zop_e              op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              take
);
    logic [BYTE_W-1:0] mask;
    logic              sel_bit;

    always_comb begin
        mask    = one_hot(idx);
        sel_bit = |(byte_in & mask);
        unique case (op)
            OP_SETB: byte_out = byte_in | mask;
            OP_CLRB: byte_out = byte_in & ~mask;
            default: byte_out = byte_in;
        endcase
        take = (op == OP_BRB1) ? sel_bit : ((op == OP_BRB0) ? !sel_bit : 1'b0);
    end
endmodule

// File: rtl/zpbit_pcgen.sv
module zpbit_pcgen
    import zpbit_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int LEN_MODIFY = 2,
    parameter int LEN_BRANCH = 3
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [BYTE_W-1:0] disp,
    input  logic              branch,
    input  logic              take,
    output logic [PC_W-1:0]   pc_next
);
    localparam logic [PC_W-1:0] STEP_MOD = PC_W'(LEN_MODIFY);
    localparam logic [PC_W-1:0] STEP_BR  = PC_W'(LEN_BRANCH);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{(PC_W-BYTE_W){disp[BYTE_W-1]}}, disp};
        seq_pc   = pc + (branch ? STEP_BR : STEP_MOD);
        pc_next  = (branch && take) ? (seq_pc + disp_ext) : seq_pc;
    end
endmodule

// File: rtl/zpbit_seq.sv
module zpbit_seq
    import zpbit_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  zdec_t             dec,
    input  logic [BYTE_W-1:0] zp_in,
    input  logic [BYTE_W-1:0] off_in,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [BYTE_W-1:0] mod_byte,
    input  logic [PC_W-1:0]   pc_calc,
    output zop_e              op_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic [PC_W-1:0]   pc_q,
    output logic [BYTE_W-1:0] off_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [PC_W-1:0]   next_pc
);
    zstate_e           state;
    logic [BYTE_W-1:0] zp_q;
    logic [BYTE_W-1:0] data_q;
    logic              done_q;
    logic [PC_W-1:0]   npc_q;
    logic              accept;

    assign accept = start && dec.legal && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= OP_CLRB;
            idx_q  <= '0;
            pc_q   <= '0;
            off_q  <= '0;
            zp_q   <= '0;
            data_q <= '0;
            done_q <= 1'b0;
            npc_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q  <= dec.op;
                        idx_q <= dec.idx;
                        pc_q  <= pc_in;
                        off_q <= off_in;
                        zp_q  <= zp_in;
                        state <= ST_READ;
                    end
                end
                ST_READ: state <= ST_HOLD;
                ST_HOLD: begin
                    data_q <= mod_byte;
                    if (op_is_branch(op_q)) begin
                        npc_q  <= pc_calc;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    npc_q  <= pc_calc;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd    = (state == ST_READ);
    assign mem_wr    = (state == ST_WRITE);
    assign mem_addr  = {{(ADDR_W-BYTE_W){1'b0}}, zp_q};
    assign mem_wdata = data_q;
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign next_pc   = npc_q;

    // R7
    rd_then_gap_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (!mem_rd && !mem_wr));

    // R7
    wr_two_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd, 2));

    // R8
    branch_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !op_is_branch(op_q));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    busy_holds_op_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(op_q) && $stable(zp_q) && $stable(pc_q)));

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !mem_rd && !mem_wr));
endmodule

// File: rtl/zpbit_unit.sv
module zpbit_unit
    import zpbit_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [7:0]        zp_addr,
    input  logic [7:0]        offset,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [PC_W-1:0]   next_pc
);
    zdec_t             dec;
    zop_e              op_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PC_W-1:0]   pc_q;
    logic [BYTE_W-1:0] off_q;
    logic [BYTE_W-1:0] mod_byte;
    logic              take;
    logic [PC_W-1:0]   pc_calc;

    zpbit_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    zpbit_bitop u_bit (
        .op       (op_q),
        .idx      (idx_q),
        .byte_in  (mem_rdata),
        .byte_out (mod_byte),
        .take     (take)
    );

    zpbit_pcgen #(.PC_W(PC_W)) u_pc (
        .pc      (pc_q),
        .disp    (off_q),
        .branch  (op_is_branch(op_q)),
        .take    (take),
        .pc_next (pc_calc)
    );

    zpbit_seq #(.PC_W(PC_W), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dec       (dec),
        .zp_in     (zp_addr),
        .off_in    (offset),
        .pc_in     (pc_in),
        .mod_byte  (mod_byte),
        .pc_calc   (pc_calc),
        .op_q      (op_q),
        .idx_q     (idx_q),
        .pc_q      (pc_q),
        .off_q     (off_q),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done),
        .next_pc   (next_pc)
    );
endmodule

// File: tb/zpbit_unit_test.sv
module zpbit_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  zp_addr = 8'h00;
    logic [7:0]  offset = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic        busy;
    logic        done;
    logic [15:0] next_pc;

    logic [7:0]  mem [256];
    int          errors = 0;
    int          checks = 0;
    int          wr_count = 0;
    int          rd_count = 0;
    logic [7:0]  cur_zp = 8'h00;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    zpbit_unit uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .zp_addr(zp_addr), .offset(offset), .pc_in(pc_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy),
        .done(done), .next_pc(next_pc)
    );

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[7:0]];
            rd_count  <= rd_count + 1;
        end
        if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    // R6 page-zero address monitor
    always @(negedge clk) begin
        if (!rst && (mem_rd || mem_wr)) begin
            checks++;
            if (mem_addr !== {8'h00, cur_zp}) begin
                errors++;
                $display("FAIL R6 mem_addr actual=%h expected=%h", mem_addr, {8'h00, cur_zp});
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] opc, input logic [7:0] zp,
                          input logic [7:0] off, input logic [15:0] pc,
                          input logic [7:0] d);
        int lat;
        int n;
        logic is_br;
        logic bitv;
        logic taken;
        logic [7:0]  exp_byte;
        logic [15:0] exp_pc;
        n     = int'(opc[6:4]);
        is_br = opc[3];
        bitv  = d[n];
        if (is_br) begin
            taken    = opc[7] ? bitv : !bitv;
            exp_byte = d;
            exp_pc   = taken ? (pc + 16'd3 + {{8{off[7]}}, off}) : (pc + 16'd3);
        end else begin
            exp_byte = opc[7] ? (d | (8'h01 << n)) : (d & ~(8'h01 << n));
            exp_pc   = pc + 16'd2;
        end
        @(negedge clk);
        mem[zp] = d;
        cur_zp  = zp;
        wr_count = 0;
        start = 1'b1; opcode = opc; zp_addr = zp; offset = off; pc_in = pc;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 12) begin
            @(negedge clk);
            lat++;
        end
        if (is_br) begin
            check(opc[7] ? "R3 next_pc" : "R4 next_pc", {16'h0, next_pc}, {16'h0, exp_pc});
            check("R8 latency", lat, 3);
            check("R8 no write", wr_count, 0);
            check("R8 memory unchanged", {24'h0, mem[zp]}, {24'h0, exp_byte});
        end else begin
            check(opc[7] ? "R1 byte" : "R2 byte", {24'h0, mem[zp]}, {24'h0, exp_byte});
            check("R5 next_pc", {16'h0, next_pc}, {16'h0, exp_pc});
            check("R7 latency", lat, 4);
            check("R7 one write", wr_count, 1);
        end
        @(negedge clk);
        check("R9 done width", {31'h0, done}, 32'h0);
        check("R9 busy after done", {31'h0, busy}, 32'h0);
    endtask

    initial begin
        logic [7:0]  pats [4];
        logic [7:0]  offs [4];
        logic [15:0] pcs  [4];
        int          rc;
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55; pats[3] = 8'hAA;
        offs[0] = 8'h7F; offs[1] = 8'h80; offs[2] = 8'h00; offs[3] = 8'hFD;
        pcs[0]  = 16'h0200; pcs[1] = 16'hFFFE; pcs[2] = 16'h0001; pcs[3] = 16'h8000;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;

        repeat (3) @(negedge clk);
        // R12 during reset
        check("R12 busy in reset", {31'h0, busy}, 32'h0);
        check("R12 strobes in reset", {30'h0, mem_rd, mem_wr}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 busy after reset", {31'h0, busy}, 32'h0);
        check("R12 done after reset", {31'h0, done}, 32'h0);

        // sweep all legal opcodes over data patterns
        for (int hi = 0; hi < 16; hi++) begin
            for (int lo = 0; lo < 2; lo++) begin
                for (int p = 0; p < 4; p++) begin
                    run_op({hi[3:0], (lo == 0) ? 4'h7 : 4'hF},
                           8'((hi * 16 + p * 4 + lo * 3 + 1) & 255),
                           offs[(hi + p) & 3], pcs[(p + lo) & 3], pats[p]);
                end
            end
        end

        // R10: start while busy
        @(negedge clk);
        mem[8'h20] = 8'hFF;
        run_op(8'hB7, 8'h10, 8'h00, 16'h1000, 8'h00);
        @(negedge clk);
        mem[8'h20] = 8'hFF;
        cur_zp = 8'h30; mem[8'h30] = 8'h00;
        start = 1'b1; opcode = 8'h87; zp_addr = 8'h30; pc_in = 16'h4000;
        @(negedge clk);
        start = 1'b1; opcode = 8'h07; zp_addr = 8'h20; pc_in = 16'h5000;
        repeat (3) @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check("R10 busy-time target untouched", {24'h0, mem[8'h20]}, 32'h000000FF);
        check("R10 first op result", {24'h0, mem[8'h30]}, 32'h00000001);
        check("R10 first op pc", {16'h0, next_pc}, 32'h00004002);

        // R11: illegal opcodes
        for (int k = 0; k < 3; k++) begin
            logic [7:0] bad;
            bad = (k == 0) ? 8'h03 : ((k == 1) ? 8'hEA : 8'h8E);
            @(negedge clk);
            mem[8'h44] = 8'h5A;
            rc = rd_count;
            start = 1'b1; opcode = bad; zp_addr = 8'h44;
            @(negedge clk);
            start = 1'b0;
            check("R11 busy stays low", {31'h0, busy}, 32'h0);
            rc = rd_count - rc;
            repeat (5) begin
                @(negedge clk);
                check("R11 no done", {31'h0, done}, 32'h0);
            end
            check("R11 no read", rc, 0);
            check("R11 memory unchanged", {24'h0, mem[8'h44]}, 32'h0000005A);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule